// File: doc/BRIEF.md
# Stretchable External Data Memory Interface

This block sits between an 8-bit controller's datapath and a 16 MB off-chip data memory. It holds the address state for those accesses: a two-byte data pointer, a page byte that picks one 64 KB segment, and a separate high-address byte used when the low address byte comes from an index register. Software loads these registers through a narrow register-write port. A single stretch field sets how many clocks each memory strobe lasts, so one design can serve fast and slow parts.

The datapath starts an access with a one-cycle request that gives a direction (read or write), an addressing mode, an index byte and a write byte. The block latches the full 24-bit address and the write byte, raises the read or write strobe for the programmed number of clocks, and drives write data onto a dedicated bus with a tri-state enable. Read data comes back on its own bus. The block captures it on the last strobe clock and then raises a one-cycle completion pulse. While an access is in progress the block reports busy, and it drops any further request.

Top module: `xmem_stretch_if`

## Requirements
- R1: A synchronous active-high reset clears the two pointer bytes, the page byte, the index-high byte, the stretch field, the captured read byte and the latched address to zero. It also drives the read strobe, write strobe, tri-state enable, busy and done low.
- R2: A register write (`reg_we` high at a clock edge) stores `reg_wdata` into the register chosen by `reg_sel`. Select 0 is pointer low, 1 is pointer high, 2 is page, 3 is index-high, and 4 is stretch, which takes bits 2:0. Selects 5 to 7 change nothing.
- R3: A request with `req_mode` = 0 (pointer mode) drives the address {page, pointer high, pointer low}, with the page on bits 23:16.
- R4: A request with `req_mode` = 1 (indexed mode) drives the address {page, index-high, `req_index`}.
- R5: The strobe rises in the cycle after the edge that accepts the request. It stays high for exactly stretch+1 clocks, using the stretch value in force at acceptance, so widths run from 1 to 8.
- R6: On a read, the `xrdata` value present during the last strobe clock appears on `rdata`. `done` is high for exactly the one cycle after the strobe falls. `rdata` changes at no other time, and a write access leaves it unchanged.
- R7: On a write (`req_write` = 1), `xwdata` carries the request's write byte and `xdata_oe` is high in exactly the cycles where `xwr` is high.
- R8: `busy` is high in every strobe cycle. A request made while busy is ignored: the address, strobe kind and strobe width of the access in flight do not change, and no second access follows.
- R9: A register write made at the same edge that accepts a request does not affect that access, because the access uses the values held before the write. Register writes made during an access do not alter it. The next access sees the new values.
- R10: `xrd` and `xwr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select for a register write |
| reg_wdata | input | 8 | Register write value |
| req_valid | input | 1 | Access request, one cycle |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_mode | input | 1 | 0 = pointer address, 1 = indexed address |
| req_index | input | 8 | Low address byte for indexed mode |
| req_wdata | input | 8 | Byte to write |
| xrdata | input | 8 | Read data from external memory |
| xaddr | output | 24 | External memory address |
| xrd | output | 1 | Read strobe |
| xwr | output | 1 | Write strobe |
| xwdata | output | 8 | Write data to external memory |
| xdata_oe | output | 1 | Tri-state enable for the write data bus |
| rdata | output | 8 | Captured read byte |
| done | output | 1 | One-cycle access completion pulse |
| busy | output | 1 | Access in progress |

## Verification
A register write can land at the same edge that accepts a request, and it can also arrive while a strobe is running. The bench writes the pointer low byte at the same edge as a request. The access must show the old pointer byte, and the following access must show the new one. The bench also rewrites the stretch field in the middle of a strobe, and the measured width must still match the value in force at acceptance. A request arriving during a strobe is a second collision: the bench judges it by the address staying fixed, the strobe kind and width not changing, and no extra strobe appearing afterwards.

// File: rtl/xmem_pkg.sv
package xmem_pkg;
  localparam int XD_W   = 8;          // data byte width
  localparam int XA_W   = 3 * XD_W;   // page + two address bytes
  localparam int STR_W  = 3;          // stretch field width
  localparam int SEL_W  = 3;          // register select width

  typedef enum logic { MODE_PTR = 1'b0, MODE_IDX = 1'b1 } xmode_e;

  localparam int SEL_PLO  = 0;
  localparam int SEL_PHI  = 1;
  localparam int SEL_PAGE = 2;
  localparam int SEL_IHI  = 3;
  localparam int SEL_STR  = 4;
  localparam int NBYTE    = 4;        // byte-wide address registers

  function automatic logic [XA_W-1:0] form_ptr_addr(
    input logic [XD_W-1:0] page, input logic [XD_W-1:0] hi, input logic [XD_W-1:0] lo);
    return {page, hi, lo};
  endfunction

  function automatic logic [XA_W-1:0] form_idx_addr(
    input logic [XD_W-1:0] page, input logic [XD_W-1:0] ihi, input logic [XD_W-1:0] idx);
    return {page, ihi, idx};
  endfunction
endpackage

// File: rtl/xmem_regs.sv
module xmem_regs
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] sel,
  input  logic [XD_W-1:0]  wdata,
  output logic [XD_W-1:0]  ptr_lo,
  output logic [XD_W-1:0]  ptr_hi,
  output logic [XD_W-1:0]  page,
  output logic [XD_W-1:0]  idx_hi,
  output logic [STR_W-1:0] stretch
);
  logic [XD_W-1:0]  bytes_q [NBYTE];
  logic [STR_W-1:0] stretch_q;

  for (genvar i = 0; i < NBYTE; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)                             bytes_q[i] <= '0;
      else if (we && sel == SEL_W'(i))     bytes_q[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                               stretch_q <= '0;
    else if (we && sel == SEL_W'(SEL_STR)) stretch_q <= wdata[STR_W-1:0];
  end

  assign ptr_lo  = bytes_q[SEL_PLO];
  assign ptr_hi  = bytes_q[SEL_PHI];
  assign page    = bytes_q[SEL_PAGE];
  assign idx_hi  = bytes_q[SEL_IHI];
  assign stretch = stretch_q;
endmodule

// File: rtl/xmem_addr_gen.sv
module xmem_addr_gen
  import xmem_pkg::*;
(
  input  xmode_e          mode,
  input  logic [XD_W-1:0] page,
  input  logic [XD_W-1:0] ptr_hi,
  input  logic [XD_W-1:0] ptr_lo,
  input  logic [XD_W-1:0] idx_hi,
  input  logic [XD_W-1:0] idx,
  output logic [XA_W-1:0] addr
);
  always_comb begin
    unique case (mode)
      MODE_IDX: addr = form_idx_addr(page, idx_hi, idx);
      default:  addr = form_ptr_addr(page, ptr_hi, ptr_lo);
    endcase
  end
endmodule

// File: rtl/xmem_strobe_ctl.sv
module xmem_strobe_ctl
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             start_write,
  input  logic [STR_W-1:0] stretch,
  input  logic [XA_W-1:0]  addr_in,
  input  logic [XD_W-1:0]  wdata_in,
  input  logic [XD_W-1:0]  xrdata,
  output logic [XA_W-1:0]  xaddr,
  output logic             xrd,
  output logic             xwr,
  output logic [XD_W-1:0]  xwdata,
  output logic             xdata_oe,
  output logic [XD_W-1:0]  rdata,
  output logic             done,
  output logic             active,
  output logic             last_cycle
);
  logic             is_wr_q;
  logic [STR_W-1:0] cnt_q;
  logic [XA_W-1:0]  addr_q;
  logic [XD_W-1:0]  wdata_q;
  logic [XD_W-1:0]  rdata_q;
  logic             done_q;
  logic             oe_q;

  assign last_cycle = active && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active  <= 1'b0;
      is_wr_q <= 1'b0;
      cnt_q   <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!active) begin
        if (start) begin
          active  <= 1'b1;
          is_wr_q <= start_write;
          oe_q    <= start_write;
          cnt_q   <= stretch;
          addr_q  <= addr_in;
          wdata_q <= wdata_in;
        end
      end else if (last_cycle) begin
        active <= 1'b0;
        oe_q   <= 1'b0;
        done_q <= 1'b1;
        if (!is_wr_q) rdata_q <= xrdata;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign xaddr    = addr_q;
  assign xrd      = active && !is_wr_q;
  assign xwr      = active && is_wr_q;
  assign xwdata   = wdata_q;
  assign xdata_oe = oe_q;
  assign rdata    = rdata_q;
  assign done     = done_q;
endmodule

// File: rtl/xmem_stretch_if.sv
module xmem_stretch_if
  import xmem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [XD_W-1:0]  reg_wdata,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_mode,
  input  logic [XD_W-1:0]  req_index,
  input  logic [XD_W-1:0]  req_wdata,
  input  logic [XD_W-1:0]  xrdata,
  output logic [XA_W-1:0]  xaddr,
  output logic             xrd,
  output logic             xwr,
  output logic [XD_W-1:0]  xwdata,
  output logic             xdata_oe,
  output logic [XD_W-1:0]  rdata,
  output logic             done,
  output logic             busy
);
  logic [XD_W-1:0]  ptr_lo, ptr_hi, page, idx_hi;
  logic [STR_W-1:0] stretch_q;
  logic [XA_W-1:0]  req_addr;
  logic             accept;
  logic             strobe_on;
  logic             strobe_last;

  xmem_regs u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .ptr_lo(ptr_lo), .ptr_hi(ptr_hi), .page(page), .idx_hi(idx_hi),
    .stretch(stretch_q)
  );

  xmem_addr_gen u_addr (
    .mode(xmode_e'(req_mode)), .page(page), .ptr_hi(ptr_hi), .ptr_lo(ptr_lo),
    .idx_hi(idx_hi), .idx(req_index), .addr(req_addr)
  );

  assign accept = req_valid && !strobe_on;

  xmem_strobe_ctl u_strobe (
    .clk(clk), .rst(rst), .start(accept), .start_write(req_write),
    .stretch(stretch_q), .addr_in(req_addr), .wdata_in(req_wdata),
    .xrdata(xrdata), .xaddr(xaddr), .xrd(xrd), .xwr(xwr), .xwdata(xwdata),
    .xdata_oe(xdata_oe), .rdata(rdata), .done(done), .active(strobe_on),
    .last_cycle(strobe_last)
  );

  assign busy = strobe_on;
endmodule

// File: rtl/xmem_stretch_chk.sv
module xmem_stretch_chk
  import xmem_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             accept,
  input logic [STR_W-1:0] stretch,
  input logic             xrd,
  input logic             xwr,
  input logic             xdata_oe,
  input logic             busy,
  input logic             done,
  input logic [XA_W-1:0]  xaddr,
  input logic [XD_W-1:0]  rdata
);
  logic [STR_W:0]   wcnt;
  logic [STR_W-1:0] wexp;
  logic             strobe;

  assign strobe = xrd || xwr;

  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
      wexp <= '0;
    end else begin
      wcnt <= strobe ? wcnt + 1'b1 : '0;
      if (accept) wexp <= stretch;
    end
  end

  AST_RD_WR_EXCL:  assert property (@(posedge clk) disable iff (rst) !(xrd && xwr));                         // R10
  AST_WIDTH:       assert property (@(posedge clk) disable iff (rst) $fell(strobe) |-> ($past(wcnt) == {1'b0, wexp})); // R5
  AST_START:       assert property (@(posedge clk) disable iff (rst) accept |=> (busy && strobe));            // R5
  AST_DONE_AFTER:  assert property (@(posedge clk) disable iff (rst) done |-> (!busy && $past(busy)));       // R6
  AST_RDATA_HOLD:  assert property (@(posedge clk) disable iff (rst) !$stable(rdata) |-> done);              // R6
  AST_OE_WR:       assert property (@(posedge clk) disable iff (rst) xdata_oe == xwr);                       // R7
  AST_ADDR_HOLD:   assert property (@(posedge clk) disable iff (rst) (busy && $past(busy)) |-> $stable(xaddr)); // R8
  AST_BUSY_STROBE: assert property (@(posedge clk) disable iff (rst) strobe |-> busy);                       // R8
endmodule

bind xmem_stretch_if xmem_stretch_chk u_chk (
  .clk(clk), .rst(rst), .accept(accept), .stretch(stretch_q), .xrd(xrd),
  .xwr(xwr), .xdata_oe(xdata_oe), .busy(busy), .done(done), .xaddr(xaddr),
  .rdata(rdata)
);

// File: tb/xmem_stretch_if_tb.sv
`timescale 1ns/1ps
module xmem_stretch_if_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [7:0] reg_wdata = '0;
  logic req_valid = 1'b0, req_write = 1'b0, req_mode = 1'b0;
  logic [7:0] req_index = '0, req_wdata = '0;
  logic [7:0] xrdata;
  logic [23:0] xaddr;
  logic xrd, xwr, xdata_oe, done, busy;
  logic [7:0] xwdata, rdata;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  assign xrdata = mem_byte(xaddr);

  xmem_stretch_if u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_write(req_write), .req_mode(req_mode),
    .req_index(req_index), .req_wdata(req_wdata), .xrdata(xrdata), .xaddr(xaddr),
    .xrd(xrd), .xwr(xwr), .xwdata(xwdata), .xdata_oe(xdata_oe), .rdata(rdata),
    .done(done), .busy(busy)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] sel, input logic [7:0] val);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = val;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // Issues one access and measures it at the ports.
  task automatic access(input logic wr, input logic md, input logic [7:0] idx,
                        input logic [7:0] wd, input logic [23:0] exp_addr,
                        input int exp_width, input string tag);
    int width = 0;
    logic [7:0] rd_before;
    @(negedge clk);
    rd_before = rdata;
    req_valid = 1'b1; req_write = wr; req_mode = md; req_index = idx; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R3/R4 address"}, 32'(xaddr), 32'(exp_addr));
    while ((xrd || xwr) && width < 20) begin
      width++;
      chk({tag, " R8 busy"}, 32'(busy), 32'd1);
      chk({tag, " R7 oe"}, 32'(xdata_oe), 32'(wr));
      chk({tag, " R10 kind"}, 32'({xrd, xwr}), wr ? 32'd1 : 32'd2);
      if (wr) chk({tag, " R7 wdata"}, 32'(xwdata), 32'(wd));
      @(negedge clk);
    end
    chk({tag, " R5 width"}, 32'(width), 32'(exp_width));
    chk({tag, " R6 done"}, 32'(done), 32'd1);
    if (wr) chk({tag, " R6 rdata kept"}, 32'(rdata), 32'(rd_before));
    else    chk({tag, " R6 rdata"}, 32'(rdata), 32'(mem_byte(exp_addr)));
    @(negedge clk);
    chk({tag, " R6 done pulse"}, 32'(done), 32'd0);
  endtask

  // wr, mode, page, ptr_hi, ptr_lo, idx_hi, idx, wdata, stretch
  localparam int NV = 6;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'h01, 8'h23, 8'h45, 8'h00, 8'h00, 8'h00, 3'd0},
    {1'b1, 1'b0, 8'hFF, 8'hFF, 8'hFF, 8'h11, 8'h22, 8'hA5, 3'd7},
    {1'b0, 1'b1, 8'h12, 8'h99, 8'h88, 8'h34, 8'h56, 8'h00, 3'd2},
    {1'b1, 1'b1, 8'h00, 8'h55, 8'h66, 8'hAB, 8'hFF, 8'h3C, 3'd4},
    {1'b0, 1'b0, 8'h80, 8'h00, 8'h01, 8'hEE, 8'h10, 8'h00, 3'd1},
    {1'b0, 1'b1, 8'h7E, 8'h42, 8'h24, 8'h00, 8'h00, 8'h00, 3'd5}
  };

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int width;
    logic [23:0] a0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 addr", 32'(xaddr), 32'd0);
    chk("R1 strobes", 32'({xrd, xwr, xdata_oe}), 32'd0);
    chk("R1 busy/done", 32'({busy, done}), 32'd0);
    chk("R1 rdata", 32'(rdata), 32'd0);
    rst = 1'b0;
    // R1: cleared registers give address 0 and a 1-clock strobe
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h000000, 1, "R1 cleared regs");

    // Table of vectors (R2, R3, R4, R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      logic [52:0] v;
      logic [23:0] ea;
      v = VEC[i];
      wr_reg(3'd0, v[34:27]);
      wr_reg(3'd1, v[42:35]);
      wr_reg(3'd2, v[50:43]);
      wr_reg(3'd3, v[26:19]);
      wr_reg(3'd4, {5'b10101, v[2:0]});
      ea = v[51] ? {v[50:43], v[26:19], v[18:11]} : {v[50:43], v[42:35], v[34:27]};
      access(v[52], v[51], v[18:11], v[10:3], ea, int'(v[2:0]) + 1, $sformatf("R2 vec%0d", i));
    end

    // R2: selects 5..7 change nothing
    wr_reg(3'd0, 8'h10); wr_reg(3'd1, 8'h20); wr_reg(3'd2, 8'h30);
    wr_reg(3'd3, 8'h40); wr_reg(3'd4, 8'h02);
    wr_reg(3'd5, 8'hFF); wr_reg(3'd6, 8'hFF); wr_reg(3'd7, 8'hFF);
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h302010, 3, "R2 ignored sel ptr");
    access(1'b0, 1'b1, 8'h77, 8'h00, 24'h304077, 3, "R2 ignored sel idx");

    // R8: request during busy is ignored
    wr_reg(3'd4, 8'h03);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_mode = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    a0 = xaddr;
    width = 0;
    while ((xrd || xwr) && width < 20) begin
      width++;
      if (width == 2) begin
        req_valid = 1'b1; req_write = 1'b1; req_mode = 1'b1; req_index = 8'hC3;
      end else begin
        req_valid = 1'b0;
      end
      chk("R8 addr held", 32'(xaddr), 32'(a0));
      chk("R8 no write", 32'(xwr), 32'd0);
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk("R8 width", 32'(width), 32'd4);
    chk("R8 done", 32'(done), 32'd1);
    @(negedge clk);
    chk("R8 no second access", 32'({xrd, xwr, busy}), 32'd0);

    // R9: register write at the accepting edge uses the old value
    wr_reg(3'd4, 8'h02);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = 3'd0; reg_wdata = 8'h77;
    req_valid = 1'b1; req_write = 1'b0; req_mode = 1'b0;
    @(negedge clk);
    reg_we = 1'b0; req_valid = 1'b0;
    chk("R9 old lo", 32'(xaddr), 32'h302010);
    // R9: stretch rewritten during the access leaves its width alone
    reg_we = 1'b1; reg_sel = 3'd4; reg_wdata = 8'h00;
    width = 0;
    while ((xrd || xwr) && width < 20) begin
      width++;
      @(negedge clk);
      reg_we = 1'b0;
    end
    chk("R9 width kept", 32'(width), 32'd3);
    chk("R9 rdata", 32'(rdata), 32'(mem_byte(24'h302010)));
    access(1'b0, 1'b0, 8'h00, 8'h00, 24'h302077, 1, "R9 new values");

    // R5/R6: widest strobe, then a write keeps the read byte
    wr_reg(3'd4, 8'h07);
    access(1'b0, 1'b1, 8'h5A, 8'h00, 24'h30405A, 8, "R5 max width");
    access(1'b1, 1'b1, 8'h5B, 8'hE1, 24'h30405B, 8, "R6 write after read");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule